// File: doc/BRIEF.md
# Edge-Selectable General Purpose Port

This block is an eight-line parallel port for general use. Each line can be set as an input or an output. Each line also has its own choice of active transition, rising or falling. A request pulse appears on that line's interrupt output whenever the chosen transition arrives at the pad. The pads are modelled as three separate vectors: an input level, an output level and an output enable. The bidirectional buffer is left to the pad ring.

A processor reaches the port through a small write-strobe register interface with three registers:

| Address | Register | Write | Read |
|---------|----------|-------|------|
| 0 | Level | sets the output latch | synchronised pad levels |
| 1 | Direction | stores the value | returns the stored value |
| 2 | Edge select | stores the value | returns the stored value |
| 3 | unused | ignored | zero |

Every pad input passes through a two-stage synchroniser. Both the level read and edge detection use the synchronised value. A separate priority controller receives the request pulses.

When the serial-status override is active, lines 0 and 1 stop following the port registers and become outputs. Line 0 shows the serial receiver's data-ready flag and line 1 shows the transmitter's space-available flag.

Top module: `edge_port`

## Requirements
- R1: After reset, every enable and output bit is 0, and the irq_pulse vector is 0. Reading addresses 0, 1 and 2 returns 0 while the pad inputs are held at 0.
- R2: Without the override, pin_oe[i] equals direction bit i. A line with enable 1 drives its output-latch bit on pin_out[i]. A line with enable 0 drives 0.
- R3: A read at address 0 returns the pad inputs after two rising clock edges. A change made before edge n is visible after edge n+1 and not after edge n.
- R4: A write at address 0 loads the output latch. Output lines show the new value right after the write edge.
- R5: With edge-select bit i at 1, a 0-to-1 change on pad i raises irq_pulse[i], and a 1-to-0 change raises nothing.
- R6: With edge-select bit i at 0, a 1-to-0 change on pad i raises irq_pulse[i], and a 0-to-1 change raises nothing.
- R7: A request pulse is high for exactly one cycle. It rises after the second rising edge that follows the pad change.
- R8: Writing the edge-select register while the pads are steady never raises a request.
- R9: While dma_mode is 1, pin_oe[1:0] are 1, pin_out[0] equals rx_full and pin_out[1] equals tx_empty. Lines 2 to 7 are unaffected, and the stored direction value still reads back unchanged.
- R10: A write to address 3 changes no register, and a read of address 3 returns 0.
- R11: Lines act independently. Pads changing in the same cycle in mixed directions produce requests only on the lines whose selected transition occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables, 1 drives the pad |
| dma_mode | input | 1 | Serial-status override for lines 0 and 1 |
| rx_full | input | 1 | Receiver data-ready flag |
| tx_empty | input | 1 | Transmitter space-available flag |
| irq_pulse | output | 8 | One-cycle request per line |

## Verification
Each edge test samples the request vector one cycle early, exactly on time and one cycle late. A detector with one flop too few or too many, or a pulse that is stretched, therefore fails at a specific sample.

Mixed-direction pad patterns are applied with split edge selections. A design that swaps the polarity of the edge-select bit, or reports both transitions, flags the wrong lines.

The edge-select register is rewritten while the pads are steady. A detector that compared against the select bit rather than the pad history would emit false requests here.

The override is tested with the direction register both set and cleared. This exposes a design that fails to force the enables, or that lets the output latch leak onto lines 0 and 1.

// File: rtl/edge_port_pkg.sv
package edge_port_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_LEVEL = 2'd0,
    REG_DIR   = 2'd1,
    REG_EDGE  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/edge_port_sync.sv
module edge_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_rest
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/edge_port_detect.sv
module edge_port_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] edge_sel,
  output logic [WIDTH-1:0] irq
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic rise, fall;
    assign rise   = lvl[g] & ~prev_q[g];
    assign fall   = ~lvl[g] & prev_q[g];
    assign irq[g] = edge_sel[g] ? rise : fall;
  end
endmodule

// File: rtl/edge_port_regs.sv
module edge_port_regs
  import edge_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  lvl,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  edge_q
);
  logic [WIDTH-1:0] data_d, dir_d, edge_d;
  logic data_en, dir_en, edge_en;

  always_comb begin
    data_en = we && (addr == REG_LEVEL);
    dir_en  = we && (addr == REG_DIR);
    edge_en = we && (addr == REG_EDGE);
    data_d  = data_en ? wdata : data_q;
    dir_d   = dir_en  ? wdata : dir_q;
    edge_d  = edge_en ? wdata : edge_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      edge_q <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
      edge_q <= edge_d;
    end
  end

  always_comb begin
    case (reg_sel_e'(addr))
      REG_LEVEL: rdata = lvl;
      REG_DIR:   rdata = dir_q;
      REG_EDGE:  rdata = edge_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/edge_port_pins.sv
module edge_port_pins #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] data,
  input  logic             dma_mode,
  input  logic             rx_full,
  input  logic             tx_empty,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic flag;
    if (g == 0) begin : g_rx
      assign flag = rx_full;
    end else if (g == 1) begin : g_tx
      assign flag = tx_empty;
    end else begin : g_plain
      assign flag = 1'b0;
    end

    if (g < 2) begin : g_shared
      assign pin_oe[g]  = dma_mode | dir[g];
      assign pin_out[g] = dma_mode ? flag : (dir[g] & data[g]);
    end else begin : g_own
      assign pin_oe[g]  = dir[g];
      assign pin_out[g] = dir[g] & data[g] & ~flag;
    end
  end
endmodule

// File: rtl/edge_port.sv
module edge_port
  import edge_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WIDTH-1:0]  cpu_wdata,
  output logic [WIDTH-1:0]  cpu_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic              dma_mode,
  input  logic              rx_full,
  input  logic              tx_empty,
  output logic [WIDTH-1:0]  irq_pulse
);
  logic [WIDTH-1:0] sync_lvl;
  logic [WIDTH-1:0] data_q, dir_q, edge_q;

  edge_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (pin_in), .dout (sync_lvl)
  );

  edge_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk (clk), .rst_n (rst_n), .we (cpu_we), .addr (cpu_addr),
    .wdata (cpu_wdata), .lvl (sync_lvl), .rdata (cpu_rdata),
    .data_q (data_q), .dir_q (dir_q), .edge_q (edge_q)
  );

  edge_port_detect #(.WIDTH(WIDTH)) u_detect (
    .clk (clk), .rst_n (rst_n), .lvl (sync_lvl), .edge_sel (edge_q),
    .irq (irq_pulse)
  );

  edge_port_pins #(.WIDTH(WIDTH)) u_pins (
    .dir (dir_q), .data (data_q), .dma_mode (dma_mode),
    .rx_full (rx_full), .tx_empty (tx_empty),
    .pin_out (pin_out), .pin_oe (pin_oe)
  );
endmodule

// File: rtl/edge_port_chk.sv
module edge_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_mode,
  input logic             rx_full,
  input logic             tx_empty,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] irq,
  input logic [WIDTH-1:0] lvl,
  input logic [WIDTH-1:0] dir,
  input logic [WIDTH-1:0] edge_sel
);
  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pin_oe) & pin_out) == '0); // R2

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_mode |-> (pin_oe == dir)); // R2

  AST_OVERRIDE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |-> (pin_oe[0] && (pin_out[0] == rx_full))); // R9

  AST_OVERRIDE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |-> (pin_oe[1] && (pin_out[1] == tx_empty))); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |=> ((irq & $past(irq)) == '0)); // R7

  AST_PULSE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(lvl ^ $past(lvl))) == '0); // R8

  AST_PULSE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & (edge_sel ^ lvl)) == '0); // R5
endmodule

bind edge_port edge_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk (clk), .rst_n (rst_n), .dma_mode (dma_mode), .rx_full (rx_full),
  .tx_empty (tx_empty), .pin_out (pin_out), .pin_oe (pin_oe),
  .irq (irq_pulse), .lvl (sync_lvl), .dir (dir_q), .edge_sel (edge_q)
);

// File: tb/edge_port_tb.sv
`timescale 1ns/1ps
module edge_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_we;
  logic [1:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic [7:0] pin_in, pin_out, pin_oe, irq_pulse;
  logic       dma_mode, rx_full, tx_empty;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic       mon_on = 1'b0;
  logic [7:0] irq_seen = 8'h00;

  always #2.5 clk = ~clk;

  edge_port u_dut (
    .clk (clk), .rst_n (rst_n), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
    .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata), .pin_in (pin_in),
    .pin_out (pin_out), .pin_oe (pin_oe), .dma_mode (dma_mode),
    .rx_full (rx_full), .tx_empty (tx_empty), .irq_pulse (irq_pulse)
  );

  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] data;
    logic       dma;
    logic       rx;
    logic       tx;
    logic [7:0] exp_oe;
    logic [7:0] exp_out;
  } vec_t;

  localparam vec_t TAB [0:7] = '{
    '{8'hFF, 8'hA5, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hA5},
    '{8'h0F, 8'hA5, 1'b0, 1'b0, 1'b0, 8'h0F, 8'h05},
    '{8'hF0, 8'h3C, 1'b0, 1'b0, 1'b0, 8'hF0, 8'h30},
    '{8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h03, 8'h01},
    '{8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h03, 8'h02},
    '{8'hC0, 8'h80, 1'b1, 1'b1, 1'b1, 8'hC3, 8'h83},
    '{8'h03, 8'h00, 1'b1, 1'b1, 1'b1, 8'h03, 8'h03},
    '{8'h03, 8'h02, 1'b0, 1'b1, 1'b1, 8'h03, 8'h02}
  };

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (mon_on) irq_seen <= irq_seen | irq_pulse;
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cycles);
    finish_up();
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    cpu_addr = a;
    #1;
    chk(req, cpu_rdata, exp);
  endtask

  // Drive the pads, then sample requests one cycle early, on time and late.
  task automatic edge_step(input string req, input logic [7:0] v, input logic [7:0] exp);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
    chk("R7 early", irq_pulse, 8'h00);
    @(negedge clk);
    chk(req, irq_pulse, exp);
    @(negedge clk);
    chk("R7 one cycle", irq_pulse, 8'h00);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = 2'd0; cpu_wdata = 8'h00;
    pin_in = 8'h00; dma_mode = 1'b0; rx_full = 1'b0; tx_empty = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 irq", irq_pulse, 8'h00);
    rd_chk("R1 level", 2'd0, 8'h00);
    rd_chk("R1 dir", 2'd1, 8'h00);
    rd_chk("R1 edge", 2'd2, 8'h00);

    // R2 R4 R9 output table
    foreach (TAB[i]) begin
      wr(2'd1, TAB[i].dir);
      wr(2'd0, TAB[i].data);
      dma_mode = TAB[i].dma; rx_full = TAB[i].rx; tx_empty = TAB[i].tx;
      #1;
      chk(TAB[i].dma ? "R9 oe" : "R2 oe", pin_oe, TAB[i].exp_oe);
      chk(TAB[i].dma ? "R9 out" : "R4 out", pin_out, TAB[i].exp_out);
    end

    // R9 stored direction survives the override
    dma_mode = 1'b1;
    wr(2'd1, 8'h00);
    rd_chk("R9 dir readback", 2'd1, 8'h00);
    chk("R9 forced oe", pin_oe, 8'h03);
    wr(2'd1, 8'h81);
    rd_chk("R9 dir readback set", 2'd1, 8'h81);
    dma_mode = 1'b0;
    #1;
    chk("R2 oe after override", pin_oe, 8'h81);
    wr(2'd1, 8'h00);

    // R10 unused address
    wr(2'd2, 8'h0F);
    wr(2'd3, 8'hFF);
    rd_chk("R10 dir kept", 2'd1, 8'h00);
    rd_chk("R10 edge kept", 2'd2, 8'h0F);
    rd_chk("R10 read zero", 2'd3, 8'h00);
    chk("R10 oe kept", pin_oe, 8'h00);

    // R3 read latency
    @(negedge clk);
    pin_in = 8'h5A;
    @(negedge clk);
    rd_chk("R3 not yet", 2'd0, 8'h00);
    @(negedge clk);
    rd_chk("R3 level", 2'd0, 8'h5A);
    @(negedge clk);
    pin_in = 8'h00;
    repeat (4) @(negedge clk);

    // R5 rising selection
    wr(2'd2, 8'hFF);
    edge_step("R5 rise", 8'hFF, 8'hFF);
    edge_step("R5 fall ignored", 8'h00, 8'h00);
    // R6 falling selection
    wr(2'd2, 8'h00);
    edge_step("R6 rise ignored", 8'hFF, 8'h00);
    edge_step("R6 fall", 8'h00, 8'hFF);
    // R11 mixed lines
    wr(2'd2, 8'h0F);
    edge_step("R11 mixed a", 8'h33, 8'h03);
    edge_step("R11 mixed b", 8'hCC, 8'h3C);

    // R8 edge-select writes with steady pads
    @(negedge clk);
    irq_seen = 8'h00;
    mon_on = 1'b1;
    wr(2'd2, 8'hFF);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h55);
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    chk("R8 no spurious", irq_seen, 8'h00);

    finish_up();
  end
endmodule